// File: doc/BRIEF.md
# Integrate-and-Fire Neuron Element

This block is one neuron of an array of configurable neural elements. Each cycle it takes up to sixteen signed weighted contributions from its input synapses, each with a valid bit. It adds every valid contribution of that cycle into one value and adds that value into a signed accumulator. The accumulator clips at its limits; it does not wrap. While the neuron is integrating, it compares the new accumulator value with a programmable threshold. When the value meets or exceeds the threshold, the neuron moves to a firing phase.

The firing phase lasts one cycle. In that cycle the spike output is high, the accumulator has already been cleared, and a feedback strobe goes to all input synapses so that they can strengthen or weaken their weights. A programmable refractory period of whole cycles follows. During the firing cycle and the refractory period, all inputs are thrown away and the accumulator stays at zero. A configuration port loads the threshold and the refractory length.

Top module: `if_neuron`

## Requirements
- R1: After synchronous reset, spike_o and feedback_o are low, the accumulator is zero and the neuron is integrating. The threshold resets to 64 and the refractory length resets to 0.
- R2: In an integrating cycle, the contributions of all lanes whose valid bit is set are added together before the threshold comparison. A lane without its valid bit set contributes nothing. Lane i holds an 8-bit two's-complement weight at in_weight[8*i+7:8*i] and its valid bit at in_valid[i].
- R3: The 12-bit signed accumulator takes the value acc + sum clipped to the range -2048 to +2047. It never wraps.
- R4: If the clipped value in an integrating cycle is greater than or equal to the signed threshold, spike_o is high in the next cycle for exactly one cycle.
- R5: feedback_o is high in exactly the cycles in which spike_o is high.
- R6: When the neuron fires, the accumulator is cleared, so integration afterwards starts again from zero.
- R7: Inputs are ignored in the spike cycle and in the following cfg_refractory cycles. After those cycles, integration resumes from zero.
- R8: With a refractory length of 0, the neuron integrates again in the cycle directly after the spike cycle.
- R9: When cfg_we is high, cfg_threshold (signed) and cfg_refractory are captured at the clock edge. They are used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_threshold | input | 12 | Signed firing threshold |
| cfg_refractory | input | 8 | Refractory length in cycles |
| in_valid | input | 16 | Per-lane valid bits |
| in_weight | input | 128 | Sixteen 8-bit signed weighted contributions |
| spike_o | output | 1 | One-cycle output spike |
| feedback_o | output | 1 | Plasticity strobe to input synapses |

## Verification
Clipping and the threshold comparison can happen in the same cycle. The comparison is made on the clipped value, so a threshold at the top of the range fires only if the accumulator saturates instead of wrapping. The bench provokes this with a threshold of +2047 and two cycles of all lanes at +127. It judges the result by a spike one cycle after the second input. It runs a matching negative case: deep negative saturation, then a known positive climb, where only a clipped accumulator crosses the threshold in the predicted cycle.

// File: rtl/if_neuron_pkg.sv
package if_neuron_pkg;

    typedef enum logic [1:0] {
        PH_INTEG = 2'd0,
        PH_FIRE  = 2'd1,
        PH_REFR  = 2'd2
    } phase_e;

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/if_cfg_regs.sv
module if_cfg_regs #(
    parameter int THR_W   = 12,
    parameter int REFR_W  = 8,
    parameter int DEF_THR = 64,
    parameter int DEF_REFR = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic signed [THR_W-1:0]  thr_in,
    input  logic        [REFR_W-1:0] refr_in,
    output logic signed [THR_W-1:0]  thr_q,
    output logic        [REFR_W-1:0] refr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= THR_W'(DEF_THR);
            refr_q <= REFR_W'(DEF_REFR);
        end else if (we) begin
            thr_q  <= thr_in;
            refr_q <= refr_in;
        end
    end
endmodule

// File: rtl/if_lane_sum.sv
module if_lane_sum #(
    parameter int N_LANES  = 16,
    parameter int W_WEIGHT = 8,
    parameter int W_SUM    = W_WEIGHT + $clog2(N_LANES)
) (
    input  logic [N_LANES-1:0]          valid,
    input  logic [N_LANES*W_WEIGHT-1:0] weights,
    output logic signed [W_SUM-1:0]     sum
);
    logic signed [W_SUM-1:0] lane_ext [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic signed [W_WEIGHT-1:0] w;
        assign w = weights[g*W_WEIGHT +: W_WEIGHT];
        assign lane_ext[g] = valid[g] ? W_SUM'(w) : '0;
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < N_LANES; i++) begin
            sum = sum + lane_ext[i];
        end
    end
endmodule

// File: rtl/if_accum.sv
module if_accum
    import if_neuron_pkg::*;
#(
    parameter int W_ACC = 12,
    parameter int W_SUM = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  phase_e                  phase,
    input  logic signed [W_SUM-1:0] sum,
    input  logic signed [W_ACC-1:0] thr,
    output logic                    fire_req,
    output logic                    fb_q
);
    localparam int ACC_HI = (1 <<< (W_ACC - 1)) - 1;
    localparam int ACC_LO = -(1 <<< (W_ACC - 1));

    logic signed [W_ACC-1:0] acc_q;
    int                      nxt_int;
    logic                    integ;

    assign integ    = (phase == PH_INTEG);
    assign nxt_int  = clamp_int(int'(acc_q) + int'(sum), ACC_LO, ACC_HI);
    assign fire_req = integ && (nxt_int >= int'(thr));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            fb_q  <= 1'b0;
        end else if (integ) begin
            fb_q  <= fire_req;
            acc_q <= fire_req ? '0 : W_ACC'(nxt_int);
        end else begin
            fb_q  <= 1'b0;
            acc_q <= '0;
        end
    end

    AST_QUIET_ACC: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_INTEG) |-> (acc_q == '0)); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (integ && !fire_req && (sum >= 0)) |=> (acc_q >= $past(acc_q))); // R3

    AST_CLEAR_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
        fire_req |=> (acc_q == '0)); // R6
endmodule

// File: rtl/if_phase_ctrl.sv
module if_phase_ctrl
    import if_neuron_pkg::*;
#(
    parameter int W_REFR = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_req,
    input  logic [W_REFR-1:0] refr,
    output phase_e            phase_q
);
    logic [W_REFR-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_INTEG;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_INTEG: if (fire_req) phase_q <= PH_FIRE;
                PH_FIRE: begin
                    if (refr == '0) begin
                        phase_q <= PH_INTEG;
                    end else begin
                        phase_q <= PH_REFR;
                        cnt_q   <= refr;
                    end
                end
                PH_REFR: begin
                    if (cnt_q == W_REFR'(1)) phase_q <= PH_INTEG;
                    else cnt_q <= cnt_q - W_REFR'(1);
                end
                default: phase_q <= PH_INTEG;
            endcase
        end
    end

    AST_SPIKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FIRE) |=> (phase_q != PH_FIRE)); // R4

    AST_REFR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FIRE && refr == '0) |=> (phase_q == PH_INTEG)); // R8

    AST_REFR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_REFR && cnt_q > W_REFR'(1)) |=> (phase_q == PH_REFR)); // R7
endmodule

// File: rtl/if_neuron.sv
module if_neuron
    import if_neuron_pkg::*;
#(
    parameter int N_LANES  = 16,
    parameter int W_WEIGHT = 8,
    parameter int W_ACC    = 12,
    parameter int W_REFR   = 8,
    parameter int DEF_THR  = 64,
    parameter int DEF_REFR = 0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic signed [W_ACC-1:0]       cfg_threshold,
    input  logic        [W_REFR-1:0]      cfg_refractory,
    input  logic        [N_LANES-1:0]     in_valid,
    input  logic [N_LANES*W_WEIGHT-1:0]   in_weight,
    output logic                          spike_o,
    output logic                          feedback_o
);
    localparam int W_SUM = W_WEIGHT + $clog2(N_LANES);

    logic signed [W_ACC-1:0]  thr_q;
    logic        [W_REFR-1:0] refr_q;
    logic signed [W_SUM-1:0]  lane_sum;
    logic                     fire_req;
    phase_e                   phase;

    if_cfg_regs #(.THR_W(W_ACC), .REFR_W(W_REFR), .DEF_THR(DEF_THR), .DEF_REFR(DEF_REFR)) cfg_i (
        .clk(clk), .rst(rst), .we(cfg_we), .thr_in(cfg_threshold),
        .refr_in(cfg_refractory), .thr_q(thr_q), .refr_q(refr_q)
    );

    if_lane_sum #(.N_LANES(N_LANES), .W_WEIGHT(W_WEIGHT), .W_SUM(W_SUM)) sum_i (
        .valid(in_valid), .weights(in_weight), .sum(lane_sum)
    );

    if_accum #(.W_ACC(W_ACC), .W_SUM(W_SUM)) acc_i (
        .clk(clk), .rst(rst), .phase(phase), .sum(lane_sum), .thr(thr_q),
        .fire_req(fire_req), .fb_q(feedback_o)
    );

    if_phase_ctrl #(.W_REFR(W_REFR)) ctrl_i (
        .clk(clk), .rst(rst), .fire_req(fire_req), .refr(refr_q), .phase_q(phase)
    );

    assign spike_o = (phase == PH_FIRE);

    AST_FB_MATCH: assert property (@(posedge clk) disable iff (rst)
        spike_o == feedback_o); // R5
endmodule

// File: tb/if_neuron_tb_top.sv
module if_neuron_tb_top;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic signed [11:0] cfg_threshold = '0;
    logic [7:0]  cfg_refractory = '0;
    logic [15:0] in_valid = '0;
    logic [127:0] in_weight;
    logic        spike_o, feedback_o;
    logic signed [7:0] drv_w [16];

    int checks = 0, errors = 0;
    int m_acc = 0, m_ph = 0, m_cnt = 0, m_thr = 64, m_refr = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    always_comb for (int i = 0; i < 16; i++) in_weight[8*i +: 8] = drv_w[i];

    if_neuron dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_threshold(cfg_threshold),
        .cfg_refractory(cfg_refractory), .in_valid(in_valid), .in_weight(in_weight),
        .spike_o(spike_o), .feedback_o(feedback_o)
    );

    function automatic int clip(int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    task automatic chk(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle with the inputs already placed in in_valid / drv_w
    task automatic cyc(string tag);
        int s, nxt;
        bit exp;
        s = 0;
        for (int i = 0; i < 16; i++) if (in_valid[i]) s += int'(drv_w[i]);
        exp = 0;
        if (m_ph == 0) begin
            nxt = clip(m_acc + s);
            if (nxt >= m_thr) begin m_acc = 0; m_ph = 1; exp = 1; end
            else m_acc = nxt;
        end else if (m_ph == 1) begin
            m_acc = 0;
            if (m_refr == 0) m_ph = 0; else begin m_ph = 2; m_cnt = m_refr; end
        end else begin
            if (m_cnt == 1) m_ph = 0; else m_cnt--;
        end
        @(posedge clk); #1;
        chk(tag, spike_o, exp, "spike");
        chk("R5", feedback_o, exp, "feedback");
        @(negedge clk);
    endtask

    task automatic drive_all(logic [15:0] v, int w);
        in_valid = v;
        for (int i = 0; i < 16; i++) drv_w[i] = 8'(w);
    endtask

    task automatic idle(string tag, int n);
        drive_all(16'h0, 0);
        for (int k = 0; k < n; k++) cyc(tag);
    endtask

    task automatic configure(int thr, int refr);
        cfg_we = 1'b1; cfg_threshold = 12'(thr); cfg_refractory = 8'(refr);
        drive_all(16'h0, 0);
        cyc("R9");
        cfg_we = 1'b0;
        m_thr = thr; m_refr = refr;
        idle("R9", 10);  // drain any firing in flight
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        drive_all(16'h0, 0);
        repeat (3) @(posedge clk);
        #1;
        chk("R1", spike_o, 1'b0, "spike in reset");
        chk("R1", feedback_o, 1'b0, "feedback in reset");
        @(negedge clk); rst = 1'b0;
        // R1: default threshold 64
        drive_all(16'h0001, 63); cyc("R1");
        drive_all(16'h0001, 1);  cyc("R1");
        idle("R1", 2);

        // R2: invalid lanes carry large weights that must not count
        configure(100, 0);
        drive_all(16'h0000, 127); drv_w[0] = 8'sd99; in_valid = 16'h0001; cyc("R2");
        drive_all(16'h0000, 127); drv_w[5] = 8'sd1; in_valid = 16'h0020; cyc("R2");
        drive_all(16'h8001, 0); drv_w[0] = 8'sd60; drv_w[15] = 8'sd40; cyc("R2");
        idle("R2", 2);

        // R3 with R4: positive saturation meets threshold 2047
        configure(2047, 0);
        drive_all(16'hFFFF, 127); cyc("R3"); cyc("R3");
        idle("R3", 2);
        // R3: negative saturation, then climb
        configure(100, 0);
        drive_all(16'hFFFF, -128); for (int k = 0; k < 5; k++) cyc("R3");
        drive_all(16'hFFFF, 127); cyc("R3");
        drive_all(16'h0001, 115); cyc("R3");
        drive_all(16'h0001, 1); cyc("R3");
        idle("R3", 2);

        // R7 and R6: inputs ignored during spike and refractory cycles
        configure(10, 3);
        drive_all(16'h0001, 10); cyc("R4");
        drive_all(16'hFFFF, 127); for (int k = 0; k < 4; k++) cyc("R7");
        drive_all(16'h0001, 9); cyc("R6");
        drive_all(16'h0001, 1); cyc("R6");
        idle("R7", 5);

        // R8: zero refractory integrates straight after the spike
        configure(10, 0);
        drive_all(16'h0001, 10); cyc("R8"); cyc("R8"); cyc("R8");
        idle("R8", 2);

        // R4 sweep over refractory lengths and thresholds
        foreach (drv_w[i]) drv_w[i] = 0;
        for (int r = 0; r < 5; r++) begin
            for (int t = 0; t < 4; t++) begin
                int thr_set [4] = '{1, 50, 300, -5};
                int refr_set [5] = '{0, 1, 2, 3, 7};
                configure(thr_set[t], refr_set[r]);
                for (int k = 0; k < 40; k++) begin
                    in_valid = 16'($urandom);
                    for (int i = 0; i < 16; i++) drv_w[i] = 8'($urandom_range(0, 60) - 20);
                    cyc("R4");
                end
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule